// File: doc/BRIEF.md
# Range-Matching TLB with Pinned Block Slots

This block is a small fully associative translation buffer. Each entry covers an inclusive range of virtual page numbers and holds a physical page base, an opaque access-rights field, a dirty flag and a trap flag. A lookup is purely combinational. It finds the lowest-numbered valid entry whose range contains the virtual page, and it returns the physical address as the entry's physical base plus the distance of the page from the entry's first page. The byte offset inside the page passes through unchanged. A miss is flagged as an instruction miss or a data miss, depending on the access kind.

The lowest `NUM_BLK` slots are pinned block slots. They are written and cleared only by explicit slot commands, and they may span any whole number of pages. The remaining slots take ordinary inserts of power-of-four sized, naturally aligned ranges. Range purges and flush-all never touch a block slot. Ordinary allocation takes a free slot first and falls back to round-robin replacement over the non-block slots.

One command can be issued per clock on the `cmd_*` pins and one lookup per clock on the `lk_*` pins. There is no back-pressure: every command is accepted on the edge at which `cmd_valid` is high. A command's effect becomes visible to lookups from the following cycle. Each command gets a one-cycle-late response on `rsp_valid`/`rsp_bad`.

Top module: `range_tlb`

## Requirements
- R1: After reset no entry is valid, lookups miss, `rsp_valid` is low and the replacement pointer is at slot `NUM_BLK`. With `lk_valid` low, `lk_hit`, `lk_miss_inst` and `lk_miss_data` are all low.
- R2: Insert (`cmd_op`=1) uses size code s=`cmd_size` to cover 4^s pages. The first page is the page of `cmd_va` aligned down to 4^s pages, and `cmd_ppn` is aligned down to the same size. Page numbers are `VA_W-PAGE_BITS` bits wide; a size beyond that covers the whole space. `cmd_rights`, `cmd_dirty` and `cmd_trap` are stored as given.
- R3: A hit returns `lk_pa` = {ppn + (vpn - first page), `lk_va[PAGE_BITS-1:0]`} in the same cycle. Command effects are seen by lookups one cycle after the command.
- R4: A valid lookup that matches no entry raises `lk_miss_inst` when `lk_fetch`=1, and `lk_miss_data` otherwise. A hit raises neither.
- R5: Before an insert is written, every valid non-block entry overlapping the new range is invalidated. Block entries are left alone.
- R6: An insert goes to the lowest invalid non-block slot, counted after the overlap removal. If none is free, it goes to the replacement pointer, which then advances and wraps from `NUM_ENT-1` back to `NUM_BLK`.
- R7: Purge (`cmd_op`=2) removes every valid non-block entry overlapping 4^n pages starting at the page of `cmd_va`, where n=`cmd_va[3:0]`. The range end saturates at the top page, and block entries survive.
- R8: Flush-all (`cmd_op`=3) invalidates all non-block slots and rewinds the replacement pointer to `NUM_BLK`. Block entries remain valid.
- R9: Block set (`cmd_op`=4) writes slot `cmd_slot` with pages `cmd_va` page … page+`cmd_len`-1 (saturating), unaligned `cmd_ppn` and `cmd_rights`, and forces dirty=1 and trap=0. If `cmd_slot` ≥ `NUM_BLK` or `cmd_len`=0, the command changes nothing and reports bad.
- R10: Block clear (`cmd_op`=5) invalidates slot `cmd_slot`. If `cmd_slot` ≥ `NUM_BLK`, it changes nothing and reports bad.
- R11: When several valid entries contain the page, the lowest slot index wins, and `lk_slot` reports that index.
- R12: `rsp_valid` is high exactly in the cycle after each accepted command. `rsp_bad` is high with it for the argument errors of R9/R10 and for op codes 0, 6 and 7, which change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 insert, 2 purge, 3 flush-all, 4 block set, 5 block clear |
| cmd_va | input | VA_W | Virtual address; low 4 bits are the purge size code |
| cmd_size | input | 4 | Insert size code (4^s pages) |
| cmd_ppn | input | PA_W-PAGE_BITS | Physical page base |
| cmd_rights | input | RIGHTS_W | Access-rights field to store |
| cmd_dirty | input | 1 | Dirty flag for insert |
| cmd_trap | input | 1 | Trap flag for insert |
| cmd_slot | input | clog2(NUM_ENT) | Slot for block set/clear |
| cmd_len | input | VA_W-PAGE_BITS | Block length in pages |
| rsp_valid | output | 1 | Response for last cycle's command |
| rsp_bad | output | 1 | Last command was rejected |
| lk_valid | input | 1 | Lookup present |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_miss_inst | output | 1 | Instruction-side miss |
| lk_miss_data | output | 1 | Data-side miss |
| lk_pa | output | PA_W | Translated physical address |
| lk_slot | output | clog2(NUM_ENT) | Index of the matching slot |
| lk_rights | output | RIGHTS_W | Rights of the matching entry |
| lk_dirty | output | 1 | Dirty flag of the matching entry |
| lk_trap | output | 1 | Trap flag of the matching entry |

## Verification
Lookup outputs are due in the cycle their address is driven, and a command's effect on them is due from the next cycle. The response pins are due one edge after the command. The bench drives both ports just after the falling edge and compares every output 1 ns later, still before the rising edge. Only after that comparison does its behavioural model apply the cycle's command, and it queues the expected response for the next cycle's comparison. Directed sequences pin down overlap removal, free-slot and round-robin choice, flush rewinding, block-slot survival and argument errors. A long random phase then mixes all commands over a small page window, so that overlaps are frequent.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_INSERT  = 3'd1,
    OP_PURGE   = 3'd2,
    OP_FLUSH   = 3'd3,
    OP_BLK_SET = 3'd4,
    OP_BLK_CLR = 3'd5
  } tlb_op_e;
endpackage

// File: rtl/range_tlb_match.sv
module range_tlb_match #(
  parameter int NUM_ENT = 16,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0] vld,
  input  logic [VPN_W-1:0]   lo [NUM_ENT],
  input  logic [VPN_W-1:0]   hi [NUM_ENT],
  input  logic [VPN_W-1:0]   vpn,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_ENT-1:0] in_rng;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign in_rng[g] = vld[g] && (vpn >= lo[g]) && (vpn <= hi[g]);
  end

  // lowest index wins
  always_comb begin
    hit = |in_rng;
    idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (in_rng[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/range_tlb_overlap.sv
module range_tlb_overlap #(
  parameter int NUM_ENT = 16,
  parameter int NUM_BLK = 4,
  parameter int VPN_W   = 20
) (
  input  logic [NUM_ENT-1:0] vld,
  input  logic [VPN_W-1:0]   lo [NUM_ENT],
  input  logic [VPN_W-1:0]   hi [NUM_ENT],
  input  logic [VPN_W-1:0]   q_lo,
  input  logic [VPN_W-1:0]   q_hi,
  output logic [NUM_ENT-1:0] kill
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ovl
    if (g < NUM_BLK) begin : g_pinned
      assign kill[g] = 1'b0;
    end else begin : g_normal
      assign kill[g] = vld[g] && (lo[g] <= q_hi) && (q_lo <= hi[g]);
    end
  end
endmodule

// File: rtl/range_tlb_victim.sv
module range_tlb_victim #(
  parameter int NUM_ENT = 16,
  parameter int NUM_BLK = 4,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] free,
  input  logic               take,
  input  logic               rewind,
  output logic [IDX_W-1:0]   pick
);
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(NUM_BLK);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_ENT - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] first_free;
  logic             any_free;

  always_comb begin
    any_free   = 1'b0;
    first_free = FIRST;
    for (int i = NUM_ENT - 1; i >= NUM_BLK; i--) begin
      if (free[i]) begin
        any_free   = 1'b1;
        first_free = IDX_W'(i);
      end
    end
    pick = any_free ? first_free : rr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= FIRST;
    end else if (rewind) begin
      rr_q <= FIRST;
    end else if (take && !any_free) begin
      rr_q <= (rr_q == LAST) ? FIRST : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int NUM_ENT   = 16,
  parameter int NUM_BLK   = 4,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int RIGHTS_W  = 7,
  localparam int IDX_W    = $clog2(NUM_ENT),
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [VA_W-1:0]     cmd_va,
  input  logic [3:0]          cmd_size,
  input  logic [PPN_W-1:0]    cmd_ppn,
  input  logic [RIGHTS_W-1:0] cmd_rights,
  input  logic                cmd_dirty,
  input  logic                cmd_trap,
  input  logic [IDX_W-1:0]    cmd_slot,
  input  logic [VPN_W-1:0]    cmd_len,
  output logic                rsp_valid,
  output logic                rsp_bad,
  input  logic                lk_valid,
  input  logic                lk_fetch,
  input  logic [VA_W-1:0]     lk_va,
  output logic                lk_hit,
  output logic                lk_miss_inst,
  output logic                lk_miss_data,
  output logic [PA_W-1:0]     lk_pa,
  output logic [IDX_W-1:0]    lk_slot,
  output logic [RIGHTS_W-1:0] lk_rights,
  output logic                lk_dirty,
  output logic                lk_trap
);
  localparam logic [NUM_ENT-1:0] BLK_MASK =
    {{(NUM_ENT - NUM_BLK){1'b0}}, {NUM_BLK{1'b1}}};

  // entry state
  logic [NUM_ENT-1:0]  vld_q, dty_q, trp_q;
  logic [VPN_W-1:0]    lo_q  [NUM_ENT];
  logic [VPN_W-1:0]    hi_q  [NUM_ENT];
  logic [PPN_W-1:0]    ppn_q [NUM_ENT];
  logic [RIGHTS_W-1:0] rgt_q [NUM_ENT];

  // 4^s pages minus one, saturated to the page-number width
  function automatic logic [VPN_W-1:0] span_m1(input logic [3:0] s);
    int sh;
    sh = 2 * int'(s);
    if (sh >= VPN_W) return '1;
    return VPN_W'((64'd1 << sh) - 64'd1);
  endfunction

  function automatic logic [VPN_W-1:0] add_sat(input logic [VPN_W-1:0] a,
                                               input logic [VPN_W-1:0] b);
    logic [VPN_W:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[VPN_W] ? '1 : t[VPN_W-1:0];
  endfunction

  // command decode
  tlb_op_e          op;
  logic [VPN_W-1:0] cmd_vpn, ins_m1, ins_lo, ins_hi, pg_hi, blk_hi;
  logic [VPN_W-1:0] q_lo, q_hi;
  logic [PPN_W-1:0] ins_ppn;
  logic             slot_ok, len_ok, cmd_bad;
  logic             do_ins, do_pur, do_all, do_bset, do_bclr;

  assign op      = tlb_op_e'(cmd_op);
  assign cmd_vpn = cmd_va[VA_W-1:PAGE_BITS];
  assign ins_m1  = span_m1(cmd_size);
  assign ins_lo  = cmd_vpn & ~ins_m1;
  assign ins_hi  = ins_lo | ins_m1;
  assign ins_ppn = cmd_ppn & ~PPN_W'(ins_m1);
  assign pg_hi   = add_sat(cmd_vpn, span_m1(cmd_va[3:0]));
  assign blk_hi  = add_sat(cmd_vpn, cmd_len - 1'b1);
  assign q_lo    = (op == OP_INSERT) ? ins_lo : cmd_vpn;
  assign q_hi    = (op == OP_INSERT) ? ins_hi : pg_hi;

  assign slot_ok = cmd_slot < IDX_W'(NUM_BLK);
  assign len_ok  = cmd_len != '0;

  assign do_ins  = cmd_valid && (op == OP_INSERT);
  assign do_pur  = cmd_valid && (op == OP_PURGE);
  assign do_all  = cmd_valid && (op == OP_FLUSH);
  assign do_bset = cmd_valid && (op == OP_BLK_SET) && slot_ok && len_ok;
  assign do_bclr = cmd_valid && (op == OP_BLK_CLR) && slot_ok;

  always_comb begin
    case (op)
      OP_INSERT, OP_PURGE, OP_FLUSH: cmd_bad = 1'b0;
      OP_BLK_SET:                    cmd_bad = !(slot_ok && len_ok);
      OP_BLK_CLR:                    cmd_bad = !slot_ok;
      default:                       cmd_bad = 1'b1;
    endcase
  end

  // overlap removal and slot choice
  logic [NUM_ENT-1:0] kill, vld_kept;
  logic [IDX_W-1:0]   pick;

  range_tlb_overlap #(
    .NUM_ENT(NUM_ENT), .NUM_BLK(NUM_BLK), .VPN_W(VPN_W)
  ) u_ovl (
    .vld(vld_q), .lo(lo_q), .hi(hi_q), .q_lo(q_lo), .q_hi(q_hi), .kill(kill)
  );

  assign vld_kept = vld_q & ~kill;

  range_tlb_victim #(
    .NUM_ENT(NUM_ENT), .NUM_BLK(NUM_BLK), .IDX_W(IDX_W)
  ) u_vic (
    .clk(clk), .rst_n(rst_n), .free(~vld_kept), .take(do_ins),
    .rewind(do_all), .pick(pick)
  );

  // next valid vector
  logic [NUM_ENT-1:0] vld_nxt;
  always_comb begin
    vld_nxt = vld_q;
    if (do_ins || do_pur) vld_nxt = vld_kept;
    if (do_ins)           vld_nxt[pick] = 1'b1;
    if (do_all)           vld_nxt = vld_q & BLK_MASK;
    if (do_bset)          vld_nxt[cmd_slot] = 1'b1;
    if (do_bclr)          vld_nxt[cmd_slot] = 1'b0;
  end

  // entry write port
  logic                wr_en;
  logic [IDX_W-1:0]    wr_idx;
  logic [VPN_W-1:0]    wr_lo, wr_hi;
  logic [PPN_W-1:0]    wr_ppn;
  logic                wr_dty, wr_trp;

  always_comb begin
    wr_en  = do_ins || do_bset;
    wr_idx = do_ins ? pick    : cmd_slot;
    wr_lo  = do_ins ? ins_lo  : cmd_vpn;
    wr_hi  = do_ins ? ins_hi  : blk_hi;
    wr_ppn = do_ins ? ins_ppn : cmd_ppn;
    wr_dty = do_ins ? cmd_dirty : 1'b1;
    wr_trp = do_ins ? cmd_trap  : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_bad   <= 1'b0;
    end else begin
      vld_q     <= vld_nxt;
      rsp_valid <= cmd_valid;
      rsp_bad   <= cmd_valid && cmd_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      lo_q[wr_idx]  <= wr_lo;
      hi_q[wr_idx]  <= wr_hi;
      ppn_q[wr_idx] <= wr_ppn;
      rgt_q[wr_idx] <= cmd_rights;
      dty_q[wr_idx] <= wr_dty;
      trp_q[wr_idx] <= wr_trp;
    end
  end

  // lookup
  logic [VPN_W-1:0] lk_vpn, pg_dist;
  logic             m_hit;
  logic [IDX_W-1:0] m_idx;

  assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];

  range_tlb_match #(
    .NUM_ENT(NUM_ENT), .VPN_W(VPN_W), .IDX_W(IDX_W)
  ) u_match (
    .vld(vld_q), .lo(lo_q), .hi(hi_q), .vpn(lk_vpn), .hit(m_hit), .idx(m_idx)
  );

  assign pg_dist      = lk_vpn - lo_q[m_idx];
  assign lk_hit       = lk_valid && m_hit;
  assign lk_miss_inst = lk_valid && !m_hit && lk_fetch;
  assign lk_miss_data = lk_valid && !m_hit && !lk_fetch;
  assign lk_slot      = lk_hit ? m_idx : '0;
  assign lk_pa        = lk_hit ? {ppn_q[m_idx] + PPN_W'(pg_dist),
                                  lk_va[PAGE_BITS-1:0]} : '0;
  assign lk_rights    = lk_hit ? rgt_q[m_idx] : '0;
  assign lk_dirty     = lk_hit && dty_q[m_idx];
  assign lk_trap      = lk_hit && trp_q[m_idx];
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int NUM_ENT   = 16,
  parameter int NUM_BLK   = 4,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = $clog2(NUM_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             rsp_valid,
  input logic             rsp_bad,
  input logic             lk_valid,
  input logic             lk_fetch,
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_hit,
  input logic             lk_miss_inst,
  input logic             lk_miss_data,
  input logic [PA_W-1:0]  lk_pa,
  input logic [IDX_W-1:0] lk_slot,
  input logic             lk_dirty,
  input logic             lk_trap
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit && !lk_miss_inst && !lk_miss_data);

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[PAGE_BITS-1:0] == lk_va[PAGE_BITS-1:0]);

  assert_hit_no_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !lk_miss_inst && !lk_miss_data);

  assert_miss_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_hit |-> (lk_miss_inst == lk_fetch) && (lk_miss_data == !lk_fetch));

  assert_flush_keeps_pinned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd3 |=> !lk_hit || (lk_slot < IDX_W'(NUM_BLK)));

  assert_pinned_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && (lk_slot < IDX_W'(NUM_BLK)) |-> lk_dirty && !lk_trap);

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  assert_rsp_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid && !rsp_bad);

  assert_bad_opcode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd0 || cmd_op > 3'd5) |=> rsp_bad);
endmodule

bind range_tlb range_tlb_chk #(
  .NUM_ENT(NUM_ENT), .NUM_BLK(NUM_BLK), .VA_W(VA_W), .PA_W(PA_W),
  .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rsp_valid(rsp_valid), .rsp_bad(rsp_bad), .lk_valid(lk_valid),
  .lk_fetch(lk_fetch), .lk_va(lk_va), .lk_hit(lk_hit),
  .lk_miss_inst(lk_miss_inst), .lk_miss_data(lk_miss_data), .lk_pa(lk_pa),
  .lk_slot(lk_slot), .lk_dirty(lk_dirty), .lk_trap(lk_trap)
);

// File: tb/tb_range_tlb.sv
module tb_range_tlb;
  localparam int NE = 16;
  localparam int NB = 4;
  localparam int TOP = 'hFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_va = '0;
  logic [3:0]  cmd_size = '0;
  logic [19:0] cmd_ppn = '0;
  logic [6:0]  cmd_rights = '0;
  logic        cmd_dirty = 1'b0, cmd_trap = 1'b0;
  logic [3:0]  cmd_slot = '0;
  logic [19:0] cmd_len = '0;
  logic        rsp_valid, rsp_bad;
  logic        lk_valid = 1'b0, lk_fetch = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_miss_inst, lk_miss_data;
  logic [31:0] lk_pa;
  logic [3:0]  lk_slot;
  logic [6:0]  lk_rights;
  logic        lk_dirty, lk_trap;

  always #2 clk = ~clk;

  range_tlb dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_va(cmd_va), .cmd_size(cmd_size), .cmd_ppn(cmd_ppn),
    .cmd_rights(cmd_rights), .cmd_dirty(cmd_dirty), .cmd_trap(cmd_trap),
    .cmd_slot(cmd_slot), .cmd_len(cmd_len), .rsp_valid(rsp_valid),
    .rsp_bad(rsp_bad), .lk_valid(lk_valid), .lk_fetch(lk_fetch),
    .lk_va(lk_va), .lk_hit(lk_hit), .lk_miss_inst(lk_miss_inst),
    .lk_miss_data(lk_miss_data), .lk_pa(lk_pa), .lk_slot(lk_slot),
    .lk_rights(lk_rights), .lk_dirty(lk_dirty), .lk_trap(lk_trap)
  );

  // behavioural reference state
  int m_valid[NE], m_lo[NE], m_hi[NE], m_ppn[NE], m_rgt[NE], m_dty[NE], m_trp[NE];
  int m_rr = NB;
  bit e_rv = 0, e_rb = 0;
  int compared = 0, mismatched = 0;
  bit finished = 0;
  bit lkv = 1;

  task automatic chk(string tag, longint got, longint exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int span(int s);
    if (2 * s >= 20) return TOP;
    return (1 << (2 * s)) - 1;
  endfunction

  function automatic int sat(int a, int b);
    if (a + b > TOP) return TOP;
    return a + b;
  endfunction

  task automatic model_check();
    int vpn, k;
    bit eh;
    vpn = int'(lk_va[31:12]);
    k = -1;
    for (int i = 0; i < NE; i++)
      if (k < 0 && m_valid[i] != 0 && vpn >= m_lo[i] && vpn <= m_hi[i]) k = i;
    eh = lk_valid && k >= 0;
    chk("R3/R11 hit", lk_hit, eh);
    chk("R4 inst miss", lk_miss_inst, lk_valid && k < 0 && lk_fetch);
    chk("R4 data miss", lk_miss_data, lk_valid && k < 0 && !lk_fetch);
    if (eh) begin
      chk("R3 pa", lk_pa, (longint'((m_ppn[k] + vpn - m_lo[k]) & TOP) << 12) | lk_va[11:0]);
      chk("R11 slot", lk_slot, k);
      chk("R2/R9 rights", lk_rights, m_rgt[k]);
      chk("R2/R9 dirty", lk_dirty, m_dty[k]);
      chk("R2/R9 trap", lk_trap, m_trp[k]);
    end
    chk("R12 rsp_valid", rsp_valid, e_rv);
    if (e_rv) chk("R12 rsp_bad", rsp_bad, e_rb);
  endtask

  task automatic kill_range(int lo, int hi);
    for (int i = NB; i < NE; i++)
      if (m_valid[i] != 0 && m_lo[i] <= hi && lo <= m_hi[i]) m_valid[i] = 0;
  endtask

  task automatic model_update();
    int vpn, m1, lo, hi, pk, sl;
    e_rv = cmd_valid;
    e_rb = 0;
    if (!cmd_valid) return;
    vpn = int'(cmd_va[31:12]);
    sl = int'(cmd_slot);
    case (int'(cmd_op))
      1: begin
        m1 = span(int'(cmd_size));
        lo = vpn & ~m1 & TOP;
        hi = lo | m1;
        kill_range(lo, hi);
        pk = -1;
        for (int i = NB; i < NE; i++) if (pk < 0 && m_valid[i] == 0) pk = i;
        if (pk < 0) begin
          pk = m_rr;
          m_rr = (m_rr == NE - 1) ? NB : m_rr + 1;
        end
        m_valid[pk] = 1; m_lo[pk] = lo; m_hi[pk] = hi;
        m_ppn[pk] = int'(cmd_ppn) & ~m1 & TOP;
        m_rgt[pk] = int'(cmd_rights); m_dty[pk] = int'(cmd_dirty); m_trp[pk] = int'(cmd_trap);
      end
      2: kill_range(vpn, sat(vpn, span(int'(cmd_va[3:0]))));
      3: begin
        for (int i = NB; i < NE; i++) m_valid[i] = 0;
        m_rr = NB;
      end
      4: begin
        if (sl < NB && cmd_len != 0) begin
          m_valid[sl] = 1; m_lo[sl] = vpn; m_hi[sl] = sat(vpn, int'(cmd_len) - 1);
          m_ppn[sl] = int'(cmd_ppn); m_rgt[sl] = int'(cmd_rights);
          m_dty[sl] = 1; m_trp[sl] = 0;
        end else e_rb = 1;
      end
      5: if (sl < NB) m_valid[sl] = 0; else e_rb = 1;
      default: e_rb = 1;
    endcase
  endtask

  task automatic cyc(bit cv, int op, int va, int sz, int ppn, int slot, int len,
                     int lva, bit lf, int rg = 5, bit dt = 0, bit tp = 1);
    @(negedge clk);
    cmd_valid = cv; cmd_op = 3'(op); cmd_va = 32'(va); cmd_size = 4'(sz);
    cmd_ppn = 20'(ppn); cmd_rights = 7'(rg); cmd_dirty = dt; cmd_trap = tp;
    cmd_slot = 4'(slot); cmd_len = 20'(len);
    lk_valid = lkv; lk_va = 32'(lva); lk_fetch = lf;
    #1;
    model_check();
    model_update();
  endtask

  task automatic look(int lva, bit lf = 0);
    cyc(0, 0, 0, 0, 0, 0, 0, lva, lf);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NE; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    look('h00013456);
    chk("R1 hit after reset", lk_hit, 0);
    chk("R1 rsp after reset", rsp_valid, 0);

    // R2 aligned power-of-four insert
    cyc(1, 1, 'h00012345, 1, 'h00ABD, 0, 0, 0, 0);
    look('h00013456);
    chk("R2 pa", lk_pa, 'h00ABF456);
    chk("R2 slot", lk_slot, 4);
    look('h00010000);
    chk("R2 base", lk_pa, 'h00ABC000);
    look('h00014000, 0);
    chk("R4 data miss", lk_miss_data, 1);
    look('h00014000, 1);
    chk("R4 inst miss", lk_miss_inst, 1);

    // R9 / R11 pinned slot over a normal entry
    cyc(1, 4, 'h00012000, 0, 'h00500, 1, 1, 0, 0, 3, 0, 1);
    look('h00012010);
    chk("R11 lowest slot", lk_slot, 1);
    chk("R9 pa", lk_pa, 'h00500010);
    chk("R9 dirty forced", lk_dirty, 1);
    chk("R9 trap forced", lk_trap, 0);
    look('h00011000);
    chk("R3 pa other page", lk_pa, 'h00ABD000);

    // R5 overlap removal
    cyc(1, 1, 'h00011000, 0, 'h00777, 0, 0, 0, 0);
    look('h00013000);
    chk("R5 old entry gone", lk_hit, 0);
    look('h00011ABC);
    chk("R5 new pa", lk_pa, 'h00777ABC);
    cyc(1, 1, 'h00012000, 0, 'h00333, 0, 0, 0, 0);
    look('h00012000);
    chk("R5 pinned survives", lk_slot, 1);

    // R7 purges
    cyc(1, 2, 'h00011000, 0, 0, 0, 0, 0, 0);
    look('h00011000);
    chk("R7 single page", lk_hit, 0);
    cyc(1, 2, 'h00012001, 0, 0, 0, 0, 0, 0);
    look('h00012000);
    chk("R7 pinned kept", lk_slot, 1);

    // R8 flush, R6 allocation order
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 0);
    look('h00012000);
    chk("R8 pinned kept", lk_hit, 1);
    for (int i = 0; i < 12; i++) cyc(1, 1, (('h100 + i) << 12), 0, 'h200 + i, 0, 0, 0, 0);
    cyc(1, 1, 'h00200000, 0, 'h900, 0, 0, 0, 0);
    look('h00200000);
    chk("R6 first victim", lk_slot, 4);
    cyc(1, 1, 'h00201000, 0, 'h901, 0, 0, 0, 0);
    look('h00201000);
    chk("R6 next victim", lk_slot, 5);
    look('h00100000);
    chk("R6 evicted", lk_hit, 0);
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) cyc(1, 1, (('h300 + i) << 12), 0, 'h300 + i, 0, 0, 0, 0);
    cyc(1, 1, 'h00400000, 0, 'h400, 0, 0, 0, 0);
    look('h00400000);
    chk("R8 pointer rewound", lk_slot, 4);

    // R9 / R10 / R12 argument errors
    cyc(1, 4, 'h00050000, 0, 1, 4, 1, 0, 0);
    look(0);
    chk("R9 bad slot", rsp_bad, 1);
    cyc(1, 4, 'h00050000, 0, 1, 0, 0, 0, 0);
    look('h00050000);
    chk("R9 zero length", rsp_bad, 1);
    chk("R9 zero length no entry", lk_hit, 0);
    cyc(1, 5, 0, 0, 0, 9, 0, 0, 0);
    look('h00012000);
    chk("R10 bad slot", rsp_bad, 1);
    chk("R10 bad slot keeps entry", lk_hit, 1);
    cyc(1, 5, 0, 0, 0, 1, 0, 0, 0);
    look('h00012000);
    chk("R10 cleared", lk_hit, 0);
    cyc(1, 7, 0, 0, 0, 0, 0, 0, 0);
    look(0);
    chk("R12 bad op", rsp_bad, 1);

    // random mix over a small window
    for (int n = 0; n < 4000; n++) begin
      int r, vpn, lvpn;
      r = int'($urandom % 100);
      vpn = int'($urandom % 64);
      lvpn = int'($urandom % 64);
      lkv = ($urandom % 10) != 0;
      if (r < 40)
        cyc(1, 1, (vpn << 12) | int'($urandom % 4096), int'($urandom % 3),
            int'($urandom % 'h100000), 0, 0, (lvpn << 12) | int'($urandom % 4096),
            bit'($urandom % 2), int'($urandom % 128), bit'($urandom % 2), bit'($urandom % 2));
      else if (r < 58)
        cyc(0, 0, 0, 0, 0, 0, 0, (lvpn << 12) | int'($urandom % 4096), bit'($urandom % 2));
      else if (r < 72)
        cyc(1, 2, (vpn << 12) | int'($urandom % 3), 0, 0, 0, 0, (lvpn << 12), bit'($urandom % 2));
      else if (r < 75)
        cyc(1, 3, 0, 0, 0, 0, 0, (lvpn << 12), 0);
      else if (r < 87)
        cyc(1, 4, vpn << 12, 0, int'($urandom % 'h100000), int'($urandom % 8),
            int'($urandom % 6), (lvpn << 12) | 'h123, 0, int'($urandom % 128));
      else if (r < 97)
        cyc(1, 5, 0, 0, 0, int'($urandom % 8), 0, (lvpn << 12), 1);
      else
        cyc(1, 6 + int'($urandom % 3) % 2, 0, 0, 0, 0, 0, (lvpn << 12), 0);
    end
    lkv = 1;
    look(0);
    finish_run();
  end
endmodule